// File: doc/BRIEF.md
# Execute Stage with Condition Flags

This block is the execute step of a simple sequential processor core. From the instruction code it picks two ALU operands. The candidates are the two register read values, the instruction constant, a fixed stack step of plus or minus four, and zero. It applies the ALU function and drives the result `val_e` combinationally. Only the conditional-branch decision depends on stored state.

A three-bit flag register holds zero, sign and overflow. It is written on the clock edge that ends an arithmetic/logic instruction and on no other edge. A jump instruction reads these stored flags through a fixed seven-entry condition table and raises `take_branch`. Fetch, memory access and write-back sit outside the block. The surrounding core presents one decoded instruction per cycle.

Instruction codes: 0 halt, 1 nop, 2 register move, 3 immediate move, 4 store, 5 load, 6 arithmetic/logic, 7 jump, 8 call, 9 return, 10 push, 11 pop. Codes 12 to 15 are unused.

Top module: `exe_stage`

## Requirements
- R1: For icode 2 (register move) `val_e` equals `val_a`, and for icode 6 the A operand is `val_a`.
- R2: For icode 3 (immediate move) `val_e` equals `val_c`. For icode 4 (store) and icode 5 (load) `val_e` equals `val_b + val_c`.
- R3: For icode 8 (call) and icode 10 (push) `val_e` equals `val_b - 4`. For icode 9 (return) and icode 11 (pop) `val_e` equals `val_b + 4`.
- R4: For icode 6 the function code selects the ALU operation: 0 gives `val_b + val_a`, 1 gives `val_b - val_a`, 2 gives `val_b & val_a`, and 3 gives `val_b ^ val_a`. Function codes 4 to 15 behave as add.
- R5: The flags are loaded at a rising clock edge only when icode is 6. Under every other icode they keep their value across edges.
- R6: On a load, ZF is set when the result is zero and SF is bit 31 of the result. OF is set on signed overflow for add and subtract, and is 0 for AND and XOR.
- R7: While reset is asserted, and after it is released, the flags are ZF=1, SF=0, OF=0.
- R8: For icode 7 the function code selects the branch condition from the stored flags. 0 is always taken, 1 is (SF^OF)|ZF, 2 is SF^OF, 3 is ZF, 4 is !ZF, 5 is !(SF^OF), and 6 is !(SF^OF)&!ZF. Codes 7 to 15 are never taken.
- R9: `take_branch` is 0 for every icode other than 7. `val_e` is 0 for icodes 0, 1, 7 and 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| icode | input | 4 | Instruction code |
| ifun | input | 4 | Function or condition code |
| val_a | input | 32 | First register read value |
| val_b | input | 32 | Second register read value |
| val_c | input | 32 | Instruction constant |
| val_e | output | 32 | Execute result |
| take_branch | output | 1 | Jump condition met |

## Verification
In an arithmetic cycle two things happen together. The result appears on `val_e`, and the flags derived from that same result are captured at the closing edge. Any branch decision taken in that cycle still uses the flags from before. The bench first sets up known flags, then applies an arithmetic instruction whose result should change them. It checks `val_e` mid-cycle, and in the cycle after the edge it sweeps all sixteen jump conditions against flags it computes itself. An instruction that does not touch the flags is then held across several edges, and the same sweep confirms the flags were left alone.

// File: rtl/exe_pkg.sv
package exe_pkg;
  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] IC_HALT    = 4'd0;
  localparam logic [CODE_W-1:0] IC_NOP     = 4'd1;
  localparam logic [CODE_W-1:0] IC_MOVE_RR = 4'd2;
  localparam logic [CODE_W-1:0] IC_MOVE_IR = 4'd3;
  localparam logic [CODE_W-1:0] IC_STORE   = 4'd4;
  localparam logic [CODE_W-1:0] IC_LOAD    = 4'd5;
  localparam logic [CODE_W-1:0] IC_ARITH   = 4'd6;
  localparam logic [CODE_W-1:0] IC_JUMP    = 4'd7;
  localparam logic [CODE_W-1:0] IC_CALL    = 4'd8;
  localparam logic [CODE_W-1:0] IC_RET     = 4'd9;
  localparam logic [CODE_W-1:0] IC_PUSH    = 4'd10;
  localparam logic [CODE_W-1:0] IC_POP     = 4'd11;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_XOR = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

  // Branch condition table, indexed by the jump function code.
  function automatic logic cond_met(input logic [CODE_W-1:0] fn, input flags_t f);
    logic lt;
    lt = f.sf ^ f.of;
    case (fn)
      4'd0:    cond_met = 1'b1;
      4'd1:    cond_met = lt | f.zf;
      4'd2:    cond_met = lt;
      4'd3:    cond_met = f.zf;
      4'd4:    cond_met = ~f.zf;
      4'd5:    cond_met = ~lt;
      4'd6:    cond_met = ~lt & ~f.zf;
      default: cond_met = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/exe_opsel.sv
module exe_opsel
  import exe_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned STACK_STEP = 4
) (
  input  logic [CODE_W-1:0] icode,
  input  logic [CODE_W-1:0] ifun,
  input  logic [DATA_W-1:0] val_a,
  input  logic [DATA_W-1:0] val_b,
  input  logic [DATA_W-1:0] val_c,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output alu_fn_e           alu_fn,
  output logic              is_arith
);
  localparam logic [DATA_W-1:0] STEP_UP = DATA_W'(STACK_STEP);
  localparam logic [DATA_W-1:0] STEP_DN = '0 - STEP_UP;

  assign is_arith = (icode == IC_ARITH);

  always_comb begin
    op_a = '0;
    op_b = '0;
    case (icode)
      IC_MOVE_RR:          op_a = val_a;
      IC_ARITH:            begin op_a = val_a;   op_b = val_b; end
      IC_MOVE_IR:          op_a = val_c;
      IC_STORE, IC_LOAD:   begin op_a = val_c;   op_b = val_b; end
      IC_CALL, IC_PUSH:    begin op_a = STEP_DN; op_b = val_b; end
      IC_RET, IC_POP:      begin op_a = STEP_UP; op_b = val_b; end
      default:             begin op_a = '0;      op_b = '0;    end
    endcase
  end

  always_comb begin
    alu_fn = ALU_ADD;
    if (is_arith && (ifun < 4'd4)) alu_fn = alu_fn_e'(ifun[1:0]);
  end
endmodule

// File: rtl/exe_alu.sv
module exe_alu
  import exe_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  alu_fn_e           alu_fn,
  output logic [DATA_W-1:0] result,
  output flags_t            flags_new
);
  localparam int unsigned MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] alu_calc(input alu_fn_e fn,
                                                  input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
    case (fn)
      ALU_SUB: alu_calc = b - a;
      ALU_AND: alu_calc = b & a;
      ALU_XOR: alu_calc = b ^ a;
      default: alu_calc = b + a;
    endcase
  endfunction

  function automatic logic ovf_calc(input alu_fn_e fn, input logic sa, input logic sb,
                                    input logic sr);
    case (fn)
      ALU_ADD: ovf_calc = (sa == sb) && (sr != sb);
      ALU_SUB: ovf_calc = (sa != sb) && (sr != sb);
      default: ovf_calc = 1'b0;
    endcase
  endfunction

  assign result       = alu_calc(alu_fn, op_a, op_b);
  assign flags_new.zf = (result == '0);
  assign flags_new.sf = result[MSB];
  assign flags_new.of = ovf_calc(alu_fn, op_a[MSB], op_b[MSB], result[MSB]);
endmodule

// File: rtl/exe_flags.sv
module exe_flags
  import exe_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  flags_t            flags_new,
  input  logic [DATA_W-1:0] result,
  input  logic [CODE_W-1:0] icode,
  input  logic [CODE_W-1:0] ifun,
  output logic              take_branch
);
  flags_t flags_q;
  logic   is_jump;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= FLAGS_RESET;
    else if (load_en) flags_q <= flags_new;
  end

  assign is_jump     = (icode == IC_JUMP);
  assign take_branch = is_jump && cond_met(ifun, flags_q);

  assert_cc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(flags_q));

  assert_zf_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (flags_q.zf == ($past(result) == '0)));

  assert_logic_of_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && (ifun == 4'd2 || ifun == 4'd3)) |=> !flags_q.of);

  assert_uncond_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump && ifun == 4'd0) |-> take_branch);

  assert_no_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_jump |-> !take_branch);
endmodule

// File: rtl/exe_stage.sv
module exe_stage
  import exe_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned STACK_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        icode,
  input  logic [3:0]        ifun,
  input  logic [DATA_W-1:0] val_a,
  input  logic [DATA_W-1:0] val_b,
  input  logic [DATA_W-1:0] val_c,
  output logic [DATA_W-1:0] val_e,
  output logic              take_branch
);
  logic [DATA_W-1:0] op_a;
  logic [DATA_W-1:0] op_b;
  alu_fn_e           alu_fn;
  logic              set_cc;
  flags_t            flags_new;

  exe_opsel #(.DATA_W(DATA_W), .STACK_STEP(STACK_STEP)) opsel_i (
    .icode    (icode),
    .ifun     (ifun),
    .val_a    (val_a),
    .val_b    (val_b),
    .val_c    (val_c),
    .op_a     (op_a),
    .op_b     (op_b),
    .alu_fn   (alu_fn),
    .is_arith (set_cc)
  );

  exe_alu #(.DATA_W(DATA_W)) alu_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .alu_fn    (alu_fn),
    .result    (val_e),
    .flags_new (flags_new)
  );

  exe_flags #(.DATA_W(DATA_W)) flags_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (set_cc),
    .flags_new   (flags_new),
    .result      (val_e),
    .icode       (icode),
    .ifun        (ifun),
    .take_branch (take_branch)
  );

  assert_nonalu_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == IC_HALT || icode == IC_NOP || icode == IC_JUMP || icode > IC_POP)
      |-> (val_e == '0));
endmodule

// File: tb/exe_stage_tb.sv
module exe_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  icode = 4'd1;
  logic [3:0]  ifun = 4'd0;
  logic [31:0] val_a = '0, val_b = '0, val_c = '0;
  logic [31:0] val_e;
  logic        take_branch;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  exe_stage dut_i (
    .clk(clk), .rst_n(rst_n), .icode(icode), .ifun(ifun),
    .val_a(val_a), .val_b(val_b), .val_c(val_c),
    .val_e(val_e), .take_branch(take_branch)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ic, input logic [3:0] fn,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    icode = ic; ifun = fn; val_a = a; val_b = b; val_c = c;
    #1;
  endtask

  // Own view of the jump table: signed less-than is sign differing from overflow.
  function automatic bit want_branch(input int code, input bit zf, input bit sf, input bit of);
    bit less;
    less = (sf != of);
    if (code == 0) return 1'b1;
    if (code == 1) return less || zf;
    if (code == 2) return less;
    if (code == 3) return zf;
    if (code == 4) return !zf;
    if (code == 5) return !less;
    if (code == 6) return !less && !zf;
    return 1'b0;
  endfunction

  task automatic sweep_jumps(input bit zf, input bit sf, input bit of, input string tag);
    for (int k = 0; k < 16; k++) begin
      drive(4'd7, 4'(k), 32'h1234_5678, 32'h9abc_def0, 32'h0000_0040);
      chk($sformatf("R8 %s cond %0d", tag, k), {31'd0, take_branch},
          {31'd0, want_branch(k, zf, sf, of)});
      if (k == 0) chk($sformatf("R9 %s jump val_e", tag), val_e, 32'd0);
    end
  endtask

  // Applies one arithmetic instruction, checks the result and the flags it leaves.
  task automatic run_arith(input logic [3:0] fn, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    longint      wide;
    bit          zf, sf, of;
    @(negedge clk);
    of = 1'b0;
    if (fn == 4'd1) begin
      r = b - a;
      wide = longint'($signed(b)) - longint'($signed(a));
      of = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
    end else if (fn == 4'd2) r = b & a;
    else if (fn == 4'd3) r = b ^ a;
    else begin
      r = b + a;
      wide = longint'($signed(b)) + longint'($signed(a));
      of = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
    end
    zf = (r == 32'd0);
    sf = r[31];
    drive(4'd6, fn, a, b, 32'hdead_beef);
    chk($sformatf("R4 fn %0d result", fn), val_e, r);
    chk("R9 arith no branch", {31'd0, take_branch}, 32'd0);
    @(negedge clk);
    sweep_jumps(zf, sf, of, $sformatf("R6 after fn %0d", fn));
  endtask

  task automatic t_reset;
    @(negedge clk);
    sweep_jumps(1'b1, 1'b0, 1'b0, "R7 reset");
  endtask

  task automatic t_moves;
    @(negedge clk);
    drive(4'd2, 4'd0, 32'h0bad_f00d, 32'h1111_1111, 32'h2222_2222);
    chk("R1 register move", val_e, 32'h0bad_f00d);
    drive(4'd3, 4'd0, 32'h0bad_f00d, 32'h1111_1111, 32'h2222_2222);
    chk("R2 immediate move", val_e, 32'h2222_2222);
    drive(4'd4, 4'd0, 32'h5, 32'h0000_1000, 32'hffff_fff8);
    chk("R2 store address", val_e, 32'h0000_0ff8);
    drive(4'd5, 4'd0, 32'h5, 32'h0000_2000, 32'h0000_0010);
    chk("R2 load address", val_e, 32'h0000_2010);
    drive(4'd0, 4'd0, 32'h5, 32'h6, 32'h7);
    chk("R9 halt val_e", val_e, 32'd0);
    drive(4'd1, 4'd0, 32'h5, 32'h6, 32'h7);
    chk("R9 nop val_e", val_e, 32'd0);
    drive(4'd13, 4'd2, 32'h5, 32'h6, 32'h7);
    chk("R9 unused code val_e", val_e, 32'd0);
    chk("R9 unused code branch", {31'd0, take_branch}, 32'd0);
  endtask

  task automatic t_stack;
    @(negedge clk);
    drive(4'd8, 4'd0, 32'h9, 32'h0000_0100, 32'h0000_0040);
    chk("R3 call", val_e, 32'h0000_00fc);
    drive(4'd10, 4'd0, 32'h9, 32'h0000_0002, 32'h0);
    chk("R3 push wrap", val_e, 32'hffff_fffe);
    drive(4'd9, 4'd0, 32'h9, 32'h0000_00fc, 32'h0);
    chk("R3 return", val_e, 32'h0000_0100);
    drive(4'd11, 4'd0, 32'h9, 32'hffff_fffc, 32'h0);
    chk("R3 pop wrap", val_e, 32'h0000_0000);
  endtask

  task automatic t_hold;
    run_arith(4'd1, 32'd9, 32'd3);
    // The non-arithmetic instructions below span several edges.
    @(negedge clk);
    drive(4'd10, 4'd0, 32'h0, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    drive(4'd2, 4'd0, 32'h0, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    drive(4'd5, 4'd1, 32'h0, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    sweep_jumps(1'b0, 1'b1, 1'b0, "R5 hold");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_moves();
    t_stack();
    run_arith(4'd1, 32'd5, 32'd5);
    run_arith(4'd0, 32'd1, 32'h7fff_ffff);
    run_arith(4'd1, 32'd1, 32'h8000_0000);
    run_arith(4'd2, 32'hf000_000f, 32'h8000_00ff);
    run_arith(4'd3, 32'h8000_0000, 32'h7fff_ffff);
    run_arith(4'd3, 32'h1357_9bdf, 32'h1357_9bdf);
    run_arith(4'd0, 32'h8000_0000, 32'h8000_0000);
    run_arith(4'd9, 32'h0000_0003, 32'hffff_fffd);
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule